// File: doc/BRIEF.md
# Serial Configuration and Readout Port

This block is the host side of a converter's control path. A host drives a chip select, a read/write select, a serial clock, a register select and a data input line. With it the host either shifts out a conversion result or a status word, or shifts in one byte of configuration. The port runs on the system clock and oversamples the host's serial clock. The pin inputs pass through a synchronizer, and the logic finds serial clock edges by comparing successive samples.

On a read, the selected word is captured at the moment the read is selected. Its MSB appears on the output at once, and each serial clock rising edge moves the output one bit along. An output enable follows the read, so the input and output lines can share one wire. On a write, the bits are gathered MSB first into a buffer that starts out as a copy of the current configuration, and the buffer is committed in one step. The port also sends single-cycle pulses to the neighbouring status logic: one when a data read is first attempted, and one when a status read ends.

The outputs toward the core carry valid-only pulses (`cfg_valid_o`, `rd_attempt_o`, `stat_rd_done_o`) and have no ready. The host clock cannot be stalled, so the consumers must accept each pulse in the cycle it appears. The conversion and status inputs are level values and are sampled without a handshake.

Top module: `serial_cfg_port`

## Requirements
- R1: `sdo_oe_o` is high only while a read is selected (chip select low, read/write select high, seen through the synchronizer), and `sdo_o` is low whenever `sdo_oe_o` is low. During a write and while idle, both are low.
- R2: With register select high, a read returns the 24-bit conversion word MSB first. The word is captured when the read is selected, so later changes on `conv_word_i` do not affect that read.
- R3: With register select low, a read returns the 16-bit status word MSB first.
- R4: The MSB is on `sdo_o` before any serial clock edge. Each serial clock rising edge advances the output by exactly one bit.
- R5: On a conversion read, serial clock pulses beyond the 24th bit output zeros.
- R6: On a status read, serial clock pulses beyond the 16th bit keep repeating the status LSB.
- R7: A read that ends early leaves nothing behind. The next read starts again at the MSB of a freshly captured word.
- R8: Write bits are taken on serial clock falling edges, MSB first, into `cfg_o` bit 7 (power-down), bit 6 (offset calibrate), bit 5 (use offset), bit 4 (channel select), bit 3 (reserved, to be written as zero) and bits 2..0 (decimation). On the 8th bit the byte is committed and `cfg_valid_o` pulses once. Any further bits in the same write are ignored.
- R9: If a write ends after k<8 bits, `cfg_o` bits 7..8-k take the received bits and the lower bits keep their previous values. The commit happens when the write ends, with one `cfg_valid_o` pulse, and also happens when k=0.
- R10: `rd_attempt_o` pulses exactly once, on the first serial clock falling edge of a conversion read. Status reads and reads with no clock never produce it.
- R11: `stat_rd_done_o` pulses once when a status read ends and never after a conversion read.
- R12: After reset, `cfg_o` equals the reset parameter (zero by default), and `sdo_oe_o`, `sdo_o` and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock |
| cs_n_i | input | 1 | Chip select, active low |
| rnw_i | input | 1 | High selects read, low selects write |
| rsel_i | input | 1 | High selects conversion word, low selects status word |
| sdi_i | input | 1 | Serial write data |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Output enable for the shared data line |
| conv_word_i | input | DATA_W (24) | Conversion word to be read |
| stat_word_i | input | STAT_W (16) | Status word to be read |
| cfg_o | output | 8 | Configuration register |
| cfg_valid_o | output | 1 | Pulse on each configuration commit |
| rd_attempt_o | output | 1 | Pulse on first falling edge of a conversion read |
| stat_rd_done_o | output | 1 | Pulse when a status read ends |

## Verification
Reads are run with full-length, over-clocked, truncated and zero-clock patterns. Comparing conversion and status reads shows apart zero padding from LSB repetition, and a truncated read followed by a full one shows whether the bit pointer rewinds. Writes of eight, more than eight, fewer than eight and zero bits show apart the commit on the eighth bit from the commit when the write ends, and show whether the unreached low bits are kept. During a read, the conversion input is changed to prove that the word was captured at selection. Random mixes of all of these also count the pulses sent to the status logic.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  // indices into the synchronized pin vector
  localparam int SY_SCLK = 0;
  localparam int SY_CSN  = 1;
  localparam int SY_RNW  = 2;
  localparam int SY_RSEL = 3;
  localparam int SY_SDI  = 4;
  localparam int SY_N    = 5;
  // reset image of the pins: select inactive, clock low
  localparam logic [SY_N-1:0] SY_IDLE = 5'b00110;

  // configuration byte layout; the host sends bit 7 first
  localparam int CFG_W       = 8;
  localparam int CFG_PWDN    = 7;
  localparam int CFG_OCAL    = 6;
  localparam int CFG_USE_OFF = 5;
  localparam int CFG_CH_SEL  = 4;
  localparam int CFG_RSVD    = 3;
  localparam int CFG_DEC_MSB = 2;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sp_rd_shift.sv
module sp_rd_shift #(
  parameter int DATA_W = 24,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic              rd_act_q,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              rsel,
  input  logic [DATA_W-1:0] conv_word,
  input  logic [STAT_W-1:0] stat_word,
  output logic              sdo,
  output logic              oe,
  output logic              rd_attempt,
  output logic              stat_done
);
  localparam int SH_W  = (DATA_W > STAT_W) ? DATA_W : STAT_W;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(SH_W);
  localparam logic [CNT_W-1:0] STAT_END = CNT_W'(STAT_W - 1);

  logic [SH_W-1:0]  shreg;
  logic [CNT_W-1:0] cnt;
  logic             sel_data, attempted, oe_q;
  logic             rd_start, rd_end, shift_ok;
  logic [SH_W-1:0]  conv_al, stat_al;

  assign rd_start = rd_act & ~rd_act_q;
  assign rd_end   = ~rd_act & rd_act_q;
  // left-align both words in the shifter
  assign conv_al  = SH_W'(conv_word) << (SH_W - DATA_W);
  assign stat_al  = SH_W'(stat_word) << (SH_W - STAT_W);
  // status stops moving once its LSB sits at the output
  assign shift_ok = sel_data | (cnt < STAT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      cnt        <= '0;
      sel_data   <= 1'b0;
      attempted  <= 1'b0;
      oe_q       <= 1'b0;
      rd_attempt <= 1'b0;
      stat_done  <= 1'b0;
    end else begin
      oe_q       <= rd_act;
      rd_attempt <= 1'b0;
      stat_done  <= rd_end & ~sel_data;
      if (rd_start) begin
        shreg     <= rsel ? conv_al : stat_al;
        cnt       <= '0;
        sel_data  <= rsel;
        attempted <= 1'b0;
      end else if (rd_act) begin
        if (sclk_rise) begin
          if (shift_ok) shreg <= shreg << 1;
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
        if (sclk_fall && sel_data && !attempted) begin
          rd_attempt <= 1'b1;
          attempted  <= 1'b1;
        end
      end
    end
  end

  assign oe  = oe_q;
  assign sdo = oe_q & shreg[SH_W-1];
endmodule

// File: rtl/sp_wr_collect.sv
module sp_wr_collect #(
  parameter int CFG_W = 8,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_act,
  input  logic             wr_act_q,
  input  logic             sclk_fall,
  input  logic             sdi,
  output logic [CFG_W-1:0] cfg,
  output logic             cfg_valid
);
  localparam int PW = $clog2(CFG_W + 1);
  localparam logic [PW-1:0] POS_FULL = PW'(CFG_W);
  localparam logic [PW-1:0] POS_LAST = PW'(CFG_W - 1);

  logic [CFG_W-1:0] buf_q, buf_nxt;
  logic [PW-1:0]    pos;
  logic             wr_start, wr_end, take;

  assign wr_start = wr_act & ~wr_act_q;
  assign wr_end   = ~wr_act & wr_act_q;
  assign take     = wr_act & ~wr_start & sclk_fall & (pos != POS_FULL);

  always_comb begin
    buf_nxt = buf_q;
    for (int i = 0; i < CFG_W; i++)
      if (i == CFG_W - 1 - int'(pos)) buf_nxt[i] = sdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= CFG_RST;
      pos       <= '0;
      cfg       <= CFG_RST;
      cfg_valid <= 1'b0;
    end else begin
      cfg_valid <= 1'b0;
      if (wr_start) begin
        buf_q <= cfg;
        pos   <= '0;
      end else if (take) begin
        buf_q <= buf_nxt;
        pos   <= pos + 1'b1;
        if (pos == POS_LAST) begin
          cfg       <= buf_nxt;
          cfg_valid <= 1'b1;
        end
      end else if (wr_end && pos != POS_FULL) begin
        cfg       <= buf_q;
        cfg_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_port_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int STAT_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              rnw_i,
  input  logic              rsel_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [DATA_W-1:0] conv_word_i,
  input  logic [STAT_W-1:0] stat_word_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              cfg_valid_o,
  output logic              rd_attempt_o,
  output logic              stat_rd_done_o
);
  logic [SY_N-1:0] pins, s;
  logic            sclk_p, csn_p, rnw_p;
  logic            sclk_rise, sclk_fall;
  logic            rd_act, rd_act_q, wr_act, wr_act_q;

  always_comb begin
    pins          = '0;
    pins[SY_SCLK] = sclk_i;
    pins[SY_CSN]  = cs_n_i;
    pins[SY_RNW]  = rnw_i;
    pins[SY_RSEL] = rsel_i;
    pins[SY_SDI]  = sdi_i;
  end

  sp_sync #(.W(SY_N), .STAGES(SYNC_STAGES), .RST_VAL(SY_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins), .q_o(s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= SY_IDLE[SY_SCLK];
      csn_p  <= SY_IDLE[SY_CSN];
      rnw_p  <= SY_IDLE[SY_RNW];
    end else begin
      sclk_p <= s[SY_SCLK];
      csn_p  <= s[SY_CSN];
      rnw_p  <= s[SY_RNW];
    end
  end

  assign sclk_rise = s[SY_SCLK] & ~sclk_p;
  assign sclk_fall = ~s[SY_SCLK] & sclk_p;
  assign rd_act    = ~s[SY_CSN] & s[SY_RNW];
  assign wr_act    = ~s[SY_CSN] & ~s[SY_RNW];
  assign rd_act_q  = ~csn_p & rnw_p;
  assign wr_act_q  = ~csn_p & ~rnw_p;

  sp_rd_shift #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .rd_act_q(rd_act_q),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rsel(s[SY_RSEL]),
    .conv_word(conv_word_i), .stat_word(stat_word_i),
    .sdo(sdo_o), .oe(sdo_oe_o), .rd_attempt(rd_attempt_o),
    .stat_done(stat_rd_done_o)
  );

  sp_wr_collect #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .wr_act_q(wr_act_q),
    .sclk_fall(sclk_fall), .sdi(s[SY_SDI]),
    .cfg(cfg_o), .cfg_valid(cfg_valid_o)
  );
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input logic [7:0] cfg_o,
  input logic       cfg_valid_o,
  input logic       rd_attempt_o,
  input logic       stat_rd_done_o,
  input logic       wr_act
);
  p_oe_off_in_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |=> !sdo_oe_o);
  p_sdo_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe_o |-> !sdo_o);
  p_cfg_moves_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid_o |-> $stable(cfg_o));
  p_attempt_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_attempt_o |-> sdo_oe_o);
  p_attempt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_attempt_o |=> !rd_attempt_o);
  p_statdone_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_done_o |-> (!sdo_oe_o && $past(sdo_oe_o)));
endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .cfg_o(cfg_o), .cfg_valid_o(cfg_valid_o), .rd_attempt_o(rd_attempt_o),
  .stat_rd_done_o(stat_rd_done_o), .wr_act(wr_act)
);

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_i = 1'b0, cs_n_i = 1'b1, rnw_i = 1'b1, rsel_i = 1'b0, sdi_i = 1'b0;
  logic        sdo_o, sdo_oe_o, cfg_valid_o, rd_attempt_o, stat_rd_done_o;
  logic [23:0] conv_word_i = '0;
  logic [15:0] stat_word_i = '0;
  logic [7:0]  cfg_o;

  int n_vec = 0, n_bad = 0;
  int n_att = 0, n_sdone = 0, n_cv = 0;
  int e_att = 0, e_sdone = 0, e_cv = 0;
  logic [7:0] e_cfg = 8'h00;
  bit done = 0;

  always #2 clk = ~clk;

  serial_cfg_port u_serial_cfg_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .rnw_i(rnw_i),
    .rsel_i(rsel_i), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .conv_word_i(conv_word_i), .stat_word_i(stat_word_i), .cfg_o(cfg_o),
    .cfg_valid_o(cfg_valid_o), .rd_attempt_o(rd_attempt_o),
    .stat_rd_done_o(stat_rd_done_o)
  );

  always @(negedge clk) begin
    if (rd_attempt_o) n_att++;
    if (stat_rd_done_o) n_sdone++;
    if (cfg_valid_o) n_cv++;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input bit is_data, input logic [23:0] cw,
                                   input logic [15:0] sw, input int i);
    if (is_data) return (i < 24) ? cw[23 - i] : 1'b0;
    return sw[15 - ((i < 15) ? i : 15)];
  endfunction

  function automatic logic [7:0] exp_cfg(input logic [7:0] old, input logic [7:0] v,
                                         input int k);
    logic [7:0] r = old;
    for (int i = 0; i < 8; i++) if (i < k) r[7 - i] = v[7 - i];
    return r;
  endfunction

  // read with nclk serial clock pulses; optionally disturb the input word
  task automatic do_read(input bit is_data, input int nclk, input bit disturb);
    logic [23:0] cw = conv_word_i;
    logic [15:0] sw = stat_word_i;
    string tag = is_data ? "R2/R4/R5" : "R3/R4/R6";
    rsel_i = is_data; rnw_i = 1'b1; cs_n_i = 1'b0;
    wt(HALF);
    for (int i = 0; i <= nclk; i++) begin
      chk("R1 oe in read", {31'd0, sdo_oe_o}, 32'd1);
      chk(tag, {31'd0, sdo_o}, {31'd0, exp_bit(is_data, cw, sw, i)});
      if (i < nclk) begin
        sclk_i = 1'b1; wt(HALF);
        if (disturb && i == 0) begin
          conv_word_i = $urandom; stat_word_i = $urandom;
        end
        sclk_i = 1'b0; wt(HALF);
      end
    end
    cs_n_i = 1'b1; wt(HALF);
    if (is_data && nclk > 0) e_att++;
    if (!is_data) e_sdone++;
    chk("R1 oe after read", {31'd0, sdo_oe_o}, 32'd0);
    chk("R10 attempt count", n_att, e_att);
    chk("R11 status-done count", n_sdone, e_sdone);
  endtask

  task automatic do_write(input logic [7:0] v, input int k);
    logic [7:0] nxt = exp_cfg(e_cfg, v, k);
    rnw_i = 1'b0; cs_n_i = 1'b0;
    wt(HALF);
    for (int i = 0; i < k; i++) begin
      sdi_i = (i < 8) ? v[7 - i] : 1'($urandom);
      sclk_i = 1'b1; wt(HALF);
      sclk_i = 1'b0; wt(HALF);
      chk("R1 oe in write", {31'd0, sdo_oe_o}, 32'd0);
      if (i == 7) chk("R8 commit on 8th bit", {24'd0, cfg_o}, {24'd0, nxt});
    end
    cs_n_i = 1'b1; rnw_i = 1'b1; wt(HALF);
    e_cfg = nxt; e_cv++;
    chk((k < 8) ? "R9 short write" : "R8 full write", {24'd0, cfg_o}, {24'd0, e_cfg});
    chk("R8/R9 commit pulses", n_cv, e_cv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    wt(4);
    rst_n = 1'b1;
    wt(4);
    // R12 reset state
    chk("R12 cfg reset", {24'd0, cfg_o}, 32'd0);
    chk("R12 oe reset", {31'd0, sdo_oe_o}, 32'd0);
    chk("R12 sdo reset", {31'd0, sdo_o}, 32'd0);
    chk("R12 pulses", n_att + n_sdone + n_cv, 0);

    conv_word_i = 24'hC3_5A_81; stat_word_i = 16'h9AB3;
    do_read(1'b1, 30, 1'b1);          // R2 snapshot, R5 zero padding
    do_read(1'b0, 22, 1'b0);          // R3, R6 LSB repeat
    conv_word_i = 24'h80_0001;
    do_read(1'b1, 5, 1'b0);           // R7 aborted read
    do_read(1'b1, 24, 1'b0);          // R7 re-read from MSB
    stat_word_i = 16'h0001;
    do_read(1'b0, 3, 1'b0);           // R7 aborted status read
    do_read(1'b0, 18, 1'b0);          // R6 repeat of a one LSB
    do_read(1'b1, 0, 1'b0);           // R10 no clock, no attempt
    do_write(8'hA5, 8);               // R8
    do_write(8'h3C, 11);              // R8 extra bits ignored
    do_write(8'h60, 3);               // R9 three bits
    do_write(8'hFF, 0);               // R9 empty write keeps value

    for (int n = 0; n < 60; n++) begin
      conv_word_i = $urandom; stat_word_i = $urandom;
      case ($urandom % 3)
        0: do_read(1'b1, $urandom % 30, 1'($urandom));
        1: do_read(1'b0, $urandom % 22, 1'($urandom));
        default: do_write(8'($urandom), $urandom % 12);
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule